// File: doc/BRIEF.md
# Bank-Group Activate Spacing Monitor

This block is a passive observer on an already decoded DRAM command stream. On every rising clock edge it samples one command slot. When that slot holds a row activate, the block measures how many clocks have passed since the previous activate to the same bank group, and since the most recent activate to any bank group. It then compares each distance with its own programmable minimum. The monitor never drives the memory traffic. Its only outputs are a report and a trigger.

When an activate comes too early, the block emits a one-clock report. The report names the rule that was broken, the bank group involved, the interval the rule demands and the interval that was actually measured. At the same moment it raises a trigger pulse for external capture equipment and advances a saturating tally of violations. A synchronous clear empties the tally and erases all activate history. The next activate after a clear is therefore treated as a first one.

Top module: `act_spacing_monitor`

## Requirements
- R1: An activate to bank group g that arrives k clocks after the previous recorded activate to g, with k below cfg_same_gap (default 6), is a violation of kind 1 (same group). At k equal to cfg_same_gap or larger there is no same-group violation, so k=5 violates and k=6 does not.
- R2: An activate whose bank group differs from the group of the most recent recorded activate, arriving k clocks after that activate with k below cfg_cross_gap (default 4), is a violation of kind 2 (cross group). The same-group interval is never applied across groups.
- R3: When one activate breaks both rules, the report shows kind 1, with the same-group minimum and the same-group distance.
- R4: A violation appears on viol_pulse in the clock cycle after the edge that sampled the offending activate. In that same cycle viol_kind, viol_bg, viol_required and viol_measured describe it. Kind encodings are 0 none, 1 same group, 2 cross group.
- R5: A measured distance stops rising at 255 clocks and never wraps. With cfg_same_gap=255, a gap of 300 clocks passes and a gap of 254 clocks violates with measured value 254.
- R6: The first activate after reset or after a clear never violates either rule.
- R7: viol_count is 0 after reset. It rises by one for each violation, becoming visible together with viol_pulse, and holds at 65535.
- R8: While clr is high at an edge, viol_count goes to 0 and all activate history is forgotten. An activate presented in that same cycle is neither recorded nor checked.
- R9: A slot with cmd_valid low, or with cmd_is_act low, has no effect on history, reports or the count.
- R10: trig_out pulses in exactly the cycles in which viol_pulse is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of count and history |
| cmd_valid | input | 1 | The command slot holds a command |
| cmd_is_act | input | 1 | The command is a row activate |
| cmd_bg | input | 2 | Bank group of the command |
| cfg_same_gap | input | 8 | Minimum clocks between activates to one group |
| cfg_cross_gap | input | 8 | Minimum clocks between activates to differing groups |
| viol_pulse | output | 1 | One-cycle violation strobe |
| trig_out | output | 1 | Capture trigger pulse |
| viol_kind | output | 2 | Broken rule: 1 same group, 2 cross group |
| viol_bg | output | 2 | Bank group of the offending activate |
| viol_required | output | 8 | Interval the broken rule demands |
| viol_measured | output | 8 | Interval actually observed |
| viol_count | output | 16 | Saturating violation tally |

## Verification
A stale or wrong per-group age is seen at the ports no later than the next activate to that group. It shows either as a violation that should not appear or as a wrong viol_measured value in the following cycle. A lost record of the last group turns cross-group checks into spurious or missing kind-2 reports on the very next activate. A counter that wraps, or that misses an increment, shows a viol_count that differs from the tally of strobes in the same cycle as the strobe. Saturation is driven all the way to its limit, so a wrap is exposed within one violation of 65535.

// File: rtl/asm_pkg.sv
`timescale 1ns/1ps
package asm_pkg;

   typedef enum logic [1:0] {
      KIND_NONE  = 2'd0,
      KIND_SAME  = 2'd1,
      KIND_CROSS = 2'd2
   } viol_kind_e;

endpackage

// File: rtl/asm_gap_tracker.sv
`timescale 1ns/1ps
module asm_gap_tracker #(
   parameter int IW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          hit,
   output logic [IW-1:0] age_o,
   output logic          seen_o
);
   localparam logic [IW-1:0] AGE_MAX = '1;
   localparam logic [IW-1:0] AGE_ONE = IW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_o <= 1'b0;
         age_o  <= '0;
      end else if (clr) begin
         seen_o <= 1'b0;
         age_o  <= '0;
      end else if (hit) begin
         seen_o <= 1'b1;
         age_o  <= AGE_ONE;
      end else if (seen_o && (age_o != AGE_MAX)) begin
         age_o  <= age_o + AGE_ONE;
      end
   end

   // R8
   clear_forgets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !seen_o);

   // R5
   age_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_o && !hit && !clr) |=> (age_o >= $past(age_o)));

endmodule

// File: rtl/asm_act_history.sv
`timescale 1ns/1ps
module asm_act_history #(
   parameter int NUM_BG = 4,
   parameter int BG_W   = 2,
   parameter int IW     = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       hit,
   input  logic [BG_W-1:0]            hit_bg,
   output logic [NUM_BG-1:0][IW-1:0]  age_o,
   output logic [NUM_BG-1:0]          seen_o,
   output logic [IW-1:0]              any_age_o,
   output logic                       any_seen_o,
   output logic [BG_W-1:0]            last_bg_o
);

   for (genvar g = 0; g < NUM_BG; g++) begin : g_trk
      logic grp_hit;
      assign grp_hit = hit && (hit_bg == BG_W'(g));
      asm_gap_tracker #(.IW(IW)) u_trk (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (clr),
         .hit    (grp_hit),
         .age_o  (age_o[g]),
         .seen_o (seen_o[g])
      );
   end

   asm_gap_tracker #(.IW(IW)) u_any (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .hit    (hit),
      .age_o  (any_age_o),
      .seen_o (any_seen_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   last_bg_o <= '0;
      else if (hit) last_bg_o <= hit_bg;
   end

   // R2
   last_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (last_bg_o == $past(hit_bg)));

endmodule

// File: rtl/asm_spacing_judge.sv
`timescale 1ns/1ps
module asm_spacing_judge
   import asm_pkg::*;
#(
   parameter int NUM_BG = 4,
   parameter int BG_W   = 2,
   parameter int IW     = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       act_i,
   input  logic [BG_W-1:0]            bg_i,
   input  logic [IW-1:0]              same_gap_i,
   input  logic [IW-1:0]              cross_gap_i,
   input  logic [NUM_BG-1:0][IW-1:0]  age_i,
   input  logic [NUM_BG-1:0]          seen_i,
   input  logic [IW-1:0]              any_age_i,
   input  logic                       any_seen_i,
   input  logic [BG_W-1:0]            last_bg_i,
   output logic                       detect_o,
   output logic                       pulse_o,
   output logic [1:0]                 kind_o,
   output logic [BG_W-1:0]            bg_o,
   output logic [IW-1:0]              req_o,
   output logic [IW-1:0]              meas_o
);
   logic           same_bad, cross_bad;
   logic [IW-1:0]  grp_age;
   viol_kind_e     kind_n;
   logic [IW-1:0]  req_n, meas_n;

   always_comb begin
      grp_age   = age_i[bg_i];
      same_bad  = seen_i[bg_i] && (grp_age < same_gap_i);
      cross_bad = any_seen_i && (bg_i != last_bg_i) && (any_age_i < cross_gap_i);
      detect_o  = act_i && (same_bad || cross_bad);
      if (same_bad) begin
         kind_n = KIND_SAME;
         req_n  = same_gap_i;
         meas_n = grp_age;
      end else if (cross_bad) begin
         kind_n = KIND_CROSS;
         req_n  = cross_gap_i;
         meas_n = any_age_i;
      end else begin
         kind_n = KIND_NONE;
         req_n  = '0;
         meas_n = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_o <= 1'b0;
         kind_o  <= KIND_NONE;
         bg_o    <= '0;
         req_o   <= '0;
         meas_o  <= '0;
      end else begin
         pulse_o <= detect_o;
         kind_o  <= detect_o ? kind_n : KIND_NONE;
         bg_o    <= detect_o ? bg_i   : '0;
         req_o   <= detect_o ? req_n  : '0;
         meas_o  <= detect_o ? meas_n : '0;
      end
   end

   // R4
   meas_below_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |-> (meas_o < req_o));

   // R3
   same_group_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i && seen_i[bg_i] && (age_i[bg_i] < same_gap_i))
         |=> (pulse_o && (kind_o == KIND_SAME)));

   // R6
   first_act_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i && !any_seen_i) |=> !pulse_o);

endmodule

// File: rtl/asm_sat_counter.sv
`timescale 1ns/1ps
module asm_sat_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] count_o
);
   localparam logic [W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          count_o <= '0;
      else if (clr)                        count_o <= '0;
      else if (inc && count_o != CNT_MAX)  count_o <= count_o + W'(1);
   end

   // R7
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr && (count_o != CNT_MAX)) |=> (count_o == $past(count_o) + W'(1)));

   // R7
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((count_o == CNT_MAX) && !clr) |=> (count_o == CNT_MAX));

   // R8
   count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count_o == '0));

endmodule

// File: rtl/act_spacing_monitor.sv
`timescale 1ns/1ps
module act_spacing_monitor #(
   parameter int NUM_BG    = 4,
   parameter int IW        = 8,
   parameter int CNT_W     = 16,
   localparam int BG_W     = $clog2(NUM_BG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             cmd_valid,
   input  logic             cmd_is_act,
   input  logic [BG_W-1:0]  cmd_bg,
   input  logic [IW-1:0]    cfg_same_gap,
   input  logic [IW-1:0]    cfg_cross_gap,
   output logic             viol_pulse,
   output logic             trig_out,
   output logic [1:0]       viol_kind,
   output logic [BG_W-1:0]  viol_bg,
   output logic [IW-1:0]    viol_required,
   output logic [IW-1:0]    viol_measured,
   output logic [CNT_W-1:0] viol_count
);

   if (NUM_BG < 2 || (NUM_BG & (NUM_BG - 1)) != 0) begin : g_bad_bg
      $error("NUM_BG must be a power of two, at least 2");
   end
   if (IW < 3) begin : g_bad_iw
      $error("IW must be at least 3");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end

   logic                      act_hit;
   logic [NUM_BG-1:0][IW-1:0] age;
   logic [NUM_BG-1:0]         seen;
   logic [IW-1:0]             any_age;
   logic                      any_seen;
   logic [BG_W-1:0]           last_bg;
   logic                      detect;
   logic                      trig_q;

   assign act_hit = cmd_valid && cmd_is_act && !clr;

   asm_act_history #(.NUM_BG(NUM_BG), .BG_W(BG_W), .IW(IW)) u_hist (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr),
      .hit        (act_hit),
      .hit_bg     (cmd_bg),
      .age_o      (age),
      .seen_o     (seen),
      .any_age_o  (any_age),
      .any_seen_o (any_seen),
      .last_bg_o  (last_bg)
   );

   asm_spacing_judge #(.NUM_BG(NUM_BG), .BG_W(BG_W), .IW(IW)) u_judge (
      .clk         (clk),
      .rst_n       (rst_n),
      .act_i       (act_hit),
      .bg_i        (cmd_bg),
      .same_gap_i  (cfg_same_gap),
      .cross_gap_i (cfg_cross_gap),
      .age_i       (age),
      .seen_i      (seen),
      .any_age_i   (any_age),
      .any_seen_i  (any_seen),
      .last_bg_i   (last_bg),
      .detect_o    (detect),
      .pulse_o     (viol_pulse),
      .kind_o      (viol_kind),
      .bg_o        (viol_bg),
      .req_o       (viol_required),
      .meas_o      (viol_measured)
   );

   asm_sat_counter #(.W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .inc     (detect),
      .count_o (viol_count)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trig_q <= 1'b0;
      else        trig_q <= detect;
   end
   assign trig_out = trig_q;

   // R10
   trig_counted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_out |-> (viol_count != '0));

endmodule

// File: tb/sim_act_spacing_monitor.sv
`timescale 1ns/1ps
module sim_act_spacing_monitor;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clr = 1'b0;
   logic       cmd_valid = 1'b0;
   logic       cmd_is_act = 1'b0;
   logic [1:0] cmd_bg = 2'd0;
   logic [7:0] cfg_same_gap = 8'd6;
   logic [7:0] cfg_cross_gap = 8'd4;
   logic       viol_pulse, trig_out;
   logic [1:0] viol_kind, viol_bg;
   logic [7:0] viol_required, viol_measured;
   logic [15:0] viol_count;

   always #(CLK_PERIOD/2) clk = ~clk;

   act_spacing_monitor u0 (
      .clk(clk), .rst_n(rst_n), .clr(clr), .cmd_valid(cmd_valid),
      .cmd_is_act(cmd_is_act), .cmd_bg(cmd_bg), .cfg_same_gap(cfg_same_gap),
      .cfg_cross_gap(cfg_cross_gap), .viol_pulse(viol_pulse), .trig_out(trig_out),
      .viol_kind(viol_kind), .viol_bg(viol_bg), .viol_required(viol_required),
      .viol_measured(viol_measured), .viol_count(viol_count)
   );

   typedef struct {
      bit          pulse;
      bit [1:0]    kind;
      bit [1:0]    bg;
      int          req;
      int          meas;
      int unsigned cnt;
      string       tag;
   } exp_t;

   exp_t q[$];
   int checks = 0;
   int errors = 0;

   // reference model state
   int          cyc = 0;
   int          last_g[4];
   bit          seen_g[4];
   int          last_any = 0;
   int          any_bg = 0;
   bit          any_seen = 0;
   int unsigned mcount = 0;
   int          sg = 6;
   int          cg = 4;

   function automatic int sat255(input int v);
      return (v > 255) ? 255 : v;
   endfunction

   task automatic step(input bit v, input bit a, input int g, input bit c, input string tag);
      exp_t e;
      int ks, ka;
      bit sh, ch;
      @(negedge clk);
      cmd_valid = v; cmd_is_act = a; cmd_bg = 2'(g); clr = c;
      cfg_same_gap = 8'(sg); cfg_cross_gap = 8'(cg);
      e.pulse = 0; e.kind = 0; e.bg = 0; e.req = 0; e.meas = 0; e.tag = tag;
      if (c) begin
         for (int i = 0; i < 4; i++) seen_g[i] = 0;
         any_seen = 0;
         mcount = 0;
      end else if (v && a) begin
         ks = seen_g[g] ? sat255(cyc - last_g[g]) : 0;
         ka = any_seen ? sat255(cyc - last_any) : 0;
         sh = seen_g[g] && (ks < sg);
         ch = any_seen && (g != any_bg) && (ka < cg);
         if (sh) begin
            e.pulse = 1; e.kind = 2'd1; e.req = sg; e.meas = ks; e.bg = 2'(g);
         end else if (ch) begin
            e.pulse = 1; e.kind = 2'd2; e.req = cg; e.meas = ka; e.bg = 2'(g);
         end
         if (e.pulse && mcount < 65535) mcount++;
         last_g[g] = cyc; seen_g[g] = 1;
         last_any = cyc; any_bg = g; any_seen = 1;
      end
      e.cnt = mcount;
      q.push_back(e);
      cyc++;
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, tag);
   endtask

   task automatic act(input int g, input string tag);
      step(1, 1, g, 0, tag);
   endtask

   // monitor: compares results one register stage after the driven slot
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t e;
            bit ok;
            e = q.pop_front();
            ok = (viol_pulse == e.pulse) && (trig_out == e.pulse) &&
                 (viol_count == 16'(e.cnt));
            if (e.pulse)
               ok = ok && (viol_kind == e.kind) && (viol_bg == e.bg) &&
                    (viol_required == 8'(e.req)) && (viol_measured == 8'(e.meas));
            checks++;
            if (!ok) begin
               errors++;
               $display("FAIL %s: got pulse=%0b trig=%0b kind=%0d bg=%0d req=%0d meas=%0d cnt=%0d; expected pulse=%0b kind=%0d bg=%0d req=%0d meas=%0d cnt=%0d",
                        e.tag, viol_pulse, trig_out, viol_kind, viol_bg, viol_required,
                        viol_measured, viol_count, e.pulse, e.kind, e.bg, e.req, e.meas, e.cnt);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (190000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: got run still active, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4; i++) begin last_g[i] = 0; seen_g[i] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R7 reset state
      checks++;
      if (viol_pulse !== 1'b0 || trig_out !== 1'b0 || viol_count !== 16'd0) begin
         errors++;
         $display("FAIL R7 reset: got pulse=%0b trig=%0b cnt=%0d, expected 0 0 0",
                  viol_pulse, trig_out, viol_count);
      end

      act(0, "R6 first activate");
      idle(4, "R1 idle");
      act(0, "R1 same group gap 5");
      idle(5, "R1 idle");
      act(0, "R1 same group gap 6");
      idle(1, "R2 idle");
      act(1, "R2 cross group gap 2");
      idle(3, "R2 idle");
      act(2, "R2 cross group gap 4");

      idle(10, "R3 idle");
      act(0, "R3 setup");
      idle(1, "R3 idle");
      act(1, "R3 cross only");
      act(0, "R3 both rules broken");

      idle(10, "R9 idle");
      act(3, "R9 setup");
      step(0, 1, 3, 0, "R9 invalid slot");
      step(0, 1, 3, 0, "R9 invalid slot");
      step(1, 0, 3, 0, "R9 non-activate");
      step(1, 0, 2, 0, "R9 non-activate");
      idle(1, "R9 idle");
      act(3, "R9 gap 6 after ignored slots");

      sg = 255;
      idle(300, "R5 idle");
      act(3, "R5 saturated gap passes");
      idle(253, "R5 idle");
      act(3, "R5 gap 254 violates");
      sg = 6;

      cg = 8;
      idle(10, "R2 idle");
      act(0, "R2 setup");
      idle(6, "R2 idle");
      act(1, "R2 programmed cross gap 8");
      cg = 4;

      step(1, 1, 0, 1, "R8 clear with activate");
      act(0, "R8 history forgotten");
      act(0, "R8 recorded after clear");

      step(0, 0, 0, 1, "R8 clear");
      for (int i = 0; i < 65540; i++) act(3, "R7 saturating count");
      step(0, 0, 0, 1, "R8 clear after saturation");
      act(2, "R8 count restarts");
      act(2, "R7 count after clear");
      idle(1, "R10 idle");

      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule